// File: doc/BRIEF.md
# Lazy Register Restore Front End

This block sits between a core's general-register read and write ports and a per-thread backing state memory. When a thread is switched in, none of its general registers are copied in. Each register carries a presence bit, and every presence bit is cleared at the switch. The program counter, status words and rename map are loaded eagerly by other logic and do not pass through this block. The first time the core reads a register that is not present, the block holds the core with a stall, requests that single register from the backing memory, installs the returned word and then lets the read complete. A core write makes a register present without any fetch.

Each register also carries a modified bit that is set only by core writes. When a switch arrives, the block walks the modified registers in ascending index order, one per cycle, and hands each one to the backing memory for the outgoing thread. Only then does it clear the presence bits and adopt the incoming thread number. Registers that were only reloaded are never written back. Only one fetch is outstanding at a time. Each fill response carries its register index and is compared with the outstanding request.

Top module: `lazy_rf_front`

## Requirements
- R1: After reset every register is absent and unmodified, the thread number is 0, stall_o, fetch_req_o, save_valid_o and fill_err_o are 0, and the first read of any register misses.
- R2: A read of a present register returns its word in the same cycle with stall_o low.
- R3: A read of an absent register raises stall_o combinationally in that cycle. In the next cycle fetch_req_o is high for exactly one cycle, with fetch_idx_o equal to the register and thread_id_o equal to the current thread.
- R4: A fill accepted in cycle r (fill_valid_i high with fill_idx_i equal to the outstanding index) installs the word. The read completes in cycle r+1 with stall_o low and the filled data, if no other miss is pending.
- R5: A core write makes the register present and modified. A later read of it returns the written word with no fetch and no stall.
- R6: When read ports 0 and 1 both miss on different registers, port 0's register is fetched first and port 1's second, with stall_o held high from the first miss until the second fill has been installed.
- R7: A core write to the register whose fetch is outstanding, in any cycle up to and including the fill cycle, wins: the fill word is discarded and reads return the core's word.
- R8: A ctx_switch_i pulse while idle starts a save walk in the next cycle. save_valid_o is high for one cycle per modified register, with save_idx_o strictly ascending and save_data_o holding its word. One cycle with save_valid_o low and stall_o high follows. After that, all registers are absent, thread_id_o takes the new number and stall_o is released.
- R9: A switch pulse that arrives while a fetch is outstanding produces no save output until the fill is accepted. The save walk then starts in the cycle after the fill.
- R10: A fill whose index differs from the outstanding request, or that arrives with no request outstanding, sets fill_err_o, which stays high until reset. The bad fill is ignored and the fetch keeps waiting.
- R11: Core writes during a save walk are ignored: they neither enter the save stream nor make the register present for the next thread.
- R12: Registers made present only by fills are not modified and are never offered on the save port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en_i | input | NRP | Per-port read enable |
| rd_addr_i | input | NRP x AW | Per-port register index |
| rd_data_o | output | NRP x DW | Per-port read data, meaningful when stall_o is low |
| stall_o | output | 1 | Core must hold its reads and retry |
| wr_en_i | input | 1 | Core write enable |
| wr_addr_i | input | AW | Core write index |
| wr_data_i | input | DW | Core write data |
| ctx_switch_i | input | 1 | One-cycle request to change thread |
| ctx_tid_i | input | TW | Incoming thread number, taken with ctx_switch_i |
| thread_id_o | output | TW | Thread owning the file; tags fetches and saves |
| fetch_req_o | output | 1 | One-cycle single-register fetch request |
| fetch_idx_o | output | AW | Register index of the outstanding fetch |
| fill_valid_i | input | 1 | Fill response valid |
| fill_idx_i | input | AW | Register index of the fill |
| fill_data_i | input | DW | Fill word |
| save_valid_o | output | 1 | A modified register is being written back |
| save_idx_o | output | AW | Index of the register being written back |
| save_data_o | output | DW | Word being written back |
| fill_err_o | output | 1 | Sticky fill-index mismatch flag |

## Verification
Two pairs of events can land in the same cycle and need care. The first pair is a core write and the fill for that same register. The first pair is provoked by writing the pending register while its fetch is outstanding, and the bench judges it by reading back the core's word, not the memory's. The second pair is a switch request and an outstanding fetch. The bench pulses the switch right after a request, confirms that no save appears before the fill, then checks the exact cycles of the modified-register walk and the refetch under the new thread number. All values are computed from an arithmetic function of thread and index.

// File: rtl/lazy_rf_pkg.sv
package lazy_rf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SAVE = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/lazy_rf_ffs.sv
// Lowest-set-bit finder used for port priority and the save walk.
module lazy_rf_ffs #(
  parameter int unsigned W = 64,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/lazy_rf_store.sv
// Register words plus per-register presence and modified bits.
module lazy_rf_store #(
  parameter int unsigned NREGS = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned NRP   = 2,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NRP-1:0][AW-1:0]  rd_addr_i,
  output logic [NRP-1:0][DW-1:0]  rd_data_o,
  output logic [NRP-1:0]          rd_present_o,
  input  logic                    core_we_i,
  input  logic [AW-1:0]           core_idx_i,
  input  logic [DW-1:0]           core_data_i,
  input  logic                    fill_we_i,
  input  logic [AW-1:0]           fill_idx_i,
  input  logic [DW-1:0]           fill_data_i,
  input  logic                    clr_present_i,
  input  logic                    pop_mod_i,
  input  logic [AW-1:0]           pop_idx_i,
  output logic [NREGS-1:0]        mod_o,
  output logic [DW-1:0]           pop_data_o
);
  logic [DW-1:0]    word_q [NREGS];
  logic [NREGS-1:0] pres_q, pres_d;
  logic [NREGS-1:0] mod_q, mod_d;
  logic [NREGS-1:0] core_oh, fill_oh, pop_oh;

  always_comb begin
    core_oh = core_we_i ? (NREGS'(1) << core_idx_i) : '0;
    fill_oh = fill_we_i ? (NREGS'(1) << fill_idx_i) : '0;
    pop_oh  = pop_mod_i ? (NREGS'(1) << pop_idx_i)  : '0;
  end

  always_comb begin
    if (clr_present_i) pres_d = '0;
    else               pres_d = pres_q | core_oh | fill_oh;
    mod_d = (mod_q & ~pop_oh) | core_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= '0;
      mod_q  <= '0;
    end else begin
      pres_q <= pres_d;
      mod_q  <= mod_d;
    end
  end

  // Word array: no reset, written only under its enables.
  always_ff @(posedge clk) begin
    if (core_we_i) word_q[core_idx_i] <= core_data_i;
    if (fill_we_i) word_q[fill_idx_i] <= fill_data_i;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    assign rd_data_o[p]    = word_q[rd_addr_i[p]];
    assign rd_present_o[p] = pres_q[rd_addr_i[p]];
  end

  assign mod_o      = mod_q;
  assign pop_data_o = word_q[pop_idx_i];
endmodule

// File: rtl/lazy_rf_ctrl.sv
// Fetch / save sequencer with one outstanding fetch.
module lazy_rf_ctrl
  import lazy_rf_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctx_sw_i,
  input  logic [TW-1:0] ctx_tid_i,
  input  logic          miss_i,
  input  logic [AW-1:0] miss_idx_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic          fill_valid_i,
  input  logic [AW-1:0] fill_idx_i,
  input  logic          any_mod_i,
  output ctl_state_e    state_o,
  output logic          core_we_o,
  output logic          fill_we_o,
  output logic          clr_present_o,
  output logic          pop_mod_o,
  output logic [TW-1:0] tid_o,
  output logic          req_o,
  output logic [AW-1:0] req_idx_o,
  output logic          err_o
);
  ctl_state_e    state_q, state_d;
  logic [AW-1:0] pend_q, pend_d;
  logic          cancel_q, cancel_d;
  logic          swp_q, swp_d;
  logic [TW-1:0] swtid_q, swtid_d;
  logic [TW-1:0] tid_q, tid_d;
  logic          req_q, req_d;
  logic          err_q, err_d;
  logic          fill_ok, fill_bad, wr_hits_pend;

  always_comb begin
    core_we_o     = wr_en_i && (state_q != ST_SAVE);
    wr_hits_pend  = core_we_o && (wr_idx_i == pend_q);
    fill_ok       = fill_valid_i && (state_q == ST_WAIT) && (fill_idx_i == pend_q);
    fill_bad      = fill_valid_i && !fill_ok;
    fill_we_o     = fill_ok && !cancel_q && !wr_hits_pend;
    pop_mod_o     = (state_q == ST_SAVE) && any_mod_i;
    clr_present_o = (state_q == ST_SAVE) && !any_mod_i;
  end

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    cancel_d = cancel_q;
    swp_d    = swp_q;
    swtid_d  = swtid_q;
    tid_d    = tid_q;
    req_d    = 1'b0;
    err_d    = err_q | fill_bad;
    unique case (state_q)
      ST_IDLE: begin
        if (ctx_sw_i) begin
          state_d = ST_SAVE;
          swtid_d = ctx_tid_i;
        end else if (miss_i) begin
          state_d  = ST_WAIT;
          pend_d   = miss_idx_i;
          cancel_d = 1'b0;
          req_d    = 1'b1;
        end
      end
      ST_WAIT: begin
        if (wr_hits_pend) cancel_d = 1'b1;
        if (ctx_sw_i) begin
          swp_d   = 1'b1;
          swtid_d = ctx_tid_i;
        end
        if (fill_ok) begin
          state_d = (swp_q || ctx_sw_i) ? ST_SAVE : ST_IDLE;
          swp_d   = 1'b0;
        end
      end
      ST_SAVE: begin
        if (ctx_sw_i) swtid_d = ctx_tid_i;
        if (!any_mod_i) begin
          state_d = ST_IDLE;
          tid_d   = swtid_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pend_q   <= '0;
      cancel_q <= 1'b0;
      swp_q    <= 1'b0;
      swtid_q  <= '0;
      tid_q    <= '0;
      req_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      pend_q   <= pend_d;
      cancel_q <= cancel_d;
      swp_q    <= swp_d;
      swtid_q  <= swtid_d;
      tid_q    <= tid_d;
      req_q    <= req_d;
      err_q    <= err_d;
    end
  end

  assign state_o   = state_q;
  assign tid_o     = tid_q;
  assign req_o     = req_q;
  assign req_idx_o = pend_q;
  assign err_o     = err_q;
endmodule

// File: rtl/lazy_rf_front.sv
module lazy_rf_front
  import lazy_rf_pkg::*;
#(
  parameter int unsigned NREGS = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned NRP   = 2,
  parameter int unsigned TW    = 4,
  localparam int unsigned AW   = $clog2(NREGS),
  localparam int unsigned PW   = (NRP > 1) ? $clog2(NRP) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NRP-1:0]         rd_en_i,
  input  logic [NRP-1:0][AW-1:0] rd_addr_i,
  output logic [NRP-1:0][DW-1:0] rd_data_o,
  output logic                   stall_o,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic                   ctx_switch_i,
  input  logic [TW-1:0]          ctx_tid_i,
  output logic [TW-1:0]          thread_id_o,
  output logic                   fetch_req_o,
  output logic [AW-1:0]          fetch_idx_o,
  input  logic                   fill_valid_i,
  input  logic [AW-1:0]          fill_idx_i,
  input  logic [DW-1:0]          fill_data_i,
  output logic                   save_valid_o,
  output logic [AW-1:0]          save_idx_o,
  output logic [DW-1:0]          save_data_o,
  output logic                   fill_err_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [NRP-1:0]   present;
  logic [NRP-1:0]   miss_vec;
  logic             miss_any;
  logic [PW-1:0]    miss_port;
  logic [AW-1:0]    miss_idx;
  logic [NREGS-1:0] mod_vec;
  logic             any_mod;
  logic [AW-1:0]    pop_idx;
  logic             core_we, fill_we, clr_present, pop_mod;
  ctl_state_e       state;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign miss_vec = rd_en_i & ~present;

  lazy_rf_ffs #(.W(NRP)) u_port_pick (
    .vec_i   (miss_vec),
    .found_o (miss_any),
    .idx_o   (miss_port)
  );
  assign miss_idx = rd_addr_i[miss_port];

  lazy_rf_ffs #(.W(NREGS)) u_save_pick (
    .vec_i   (mod_vec),
    .found_o (any_mod),
    .idx_o   (pop_idx)
  );

  lazy_rf_store #(.NREGS(NREGS), .DW(DW), .NRP(NRP)) u_store (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .rd_addr_i     (rd_addr_i),
    .rd_data_o     (rd_data_o),
    .rd_present_o  (present),
    .core_we_i     (core_we),
    .core_idx_i    (wr_addr_i),
    .core_data_i   (wr_data_i),
    .fill_we_i     (fill_we),
    .fill_idx_i    (fill_idx_i),
    .fill_data_i   (fill_data_i),
    .clr_present_i (clr_present),
    .pop_mod_i     (pop_mod),
    .pop_idx_i     (pop_idx),
    .mod_o         (mod_vec),
    .pop_data_o    (save_data_o)
  );

  lazy_rf_ctrl #(.AW(AW), .TW(TW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .ctx_sw_i      (ctx_switch_i),
    .ctx_tid_i     (ctx_tid_i),
    .miss_i        (miss_any),
    .miss_idx_i    (miss_idx),
    .wr_en_i       (wr_en_i),
    .wr_idx_i      (wr_addr_i),
    .fill_valid_i  (fill_valid_i),
    .fill_idx_i    (fill_idx_i),
    .any_mod_i     (any_mod),
    .state_o       (state),
    .core_we_o     (core_we),
    .fill_we_o     (fill_we),
    .clr_present_o (clr_present),
    .pop_mod_o     (pop_mod),
    .tid_o         (thread_id_o),
    .req_o         (fetch_req_o),
    .req_idx_o     (fetch_idx_o),
    .err_o         (fill_err_o)
  );

  assign stall_o      = (state != ST_IDLE) || miss_any;
  assign save_valid_o = pop_mod;
  assign save_idx_o   = pop_idx;
endmodule

// File: rtl/lazy_rf_front_chk.sv
module lazy_rf_front_chk #(
  parameter int unsigned AW = 6,
  parameter int unsigned TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall_o,
  input logic          fetch_req_o,
  input logic          save_valid_o,
  input logic [AW-1:0] save_idx_o,
  input logic          fill_err_o,
  input logic [TW-1:0] thread_id_o
);
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |=> !fetch_req_o);
  p_req_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |-> stall_o);
  p_save_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid_o |-> stall_o);
  p_save_ascend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (save_valid_o && $past(save_valid_o)) |-> (save_idx_o > $past(save_idx_o)));
  p_tid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_o |=> $stable(thread_id_o));
  p_no_req_in_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid_o |-> !fetch_req_o);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err_o |=> fill_err_o);
endmodule

bind lazy_rf_front lazy_rf_front_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .stall_o      (stall_o),
  .fetch_req_o  (fetch_req_o),
  .save_valid_o (save_valid_o),
  .save_idx_o   (save_idx_o),
  .fill_err_o   (fill_err_o),
  .thread_id_o  (thread_id_o)
);

// File: tb/lazy_rf_front_tb.sv
`timescale 1ns/1ps
module lazy_rf_front_tb;
  localparam int NREGS = 64;
  localparam int DW    = 32;
  localparam int NRP   = 2;
  localparam int TW    = 4;
  localparam int AW    = 6;

  logic                   clk;
  logic                   rst_n;
  logic [NRP-1:0]         rd_en;
  logic [NRP-1:0][AW-1:0] rd_addr;
  logic [NRP-1:0][DW-1:0] rd_data;
  logic                   stall;
  logic                   wr_en;
  logic [AW-1:0]          wr_addr;
  logic [DW-1:0]          wr_data;
  logic                   ctx_sw;
  logic [TW-1:0]          ctx_tid;
  logic [TW-1:0]          tid;
  logic                   freq;
  logic [AW-1:0]          fidx;
  logic                   fill_v;
  logic [AW-1:0]          fill_idx;
  logic [DW-1:0]          fill_data;
  logic                   sv_v;
  logic [AW-1:0]          sv_idx;
  logic [DW-1:0]          sv_data;
  logic                   ferr;

  int n_tests = 0;
  int n_fail  = 0;
  logic [NREGS-1:0] sh_valid;
  logic [NREGS-1:0] sh_mod;
  logic [DW-1:0]    sh_val [NREGS];
  logic [TW-1:0]    cur_tid;

  lazy_rf_front #(.NREGS(NREGS), .DW(DW), .NRP(NRP), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .stall_o(stall),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ctx_switch_i(ctx_sw), .ctx_tid_i(ctx_tid), .thread_id_o(tid),
    .fetch_req_o(freq), .fetch_idx_o(fidx),
    .fill_valid_i(fill_v), .fill_idx_i(fill_idx), .fill_data_i(fill_data),
    .save_valid_o(sv_v), .save_idx_o(sv_idx), .save_data_o(sv_data),
    .fill_err_o(ferr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mval(input logic [TW-1:0] t, input int idx);
    return 32'hA500_0000 | (32'(t) << 16) | (32'(idx) << 8) | (32'(idx) ^ 32'h3C);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic core_write(input int idx, input logic [DW-1:0] v);
    wr_en = 1'b1; wr_addr = AW'(idx); wr_data = v;
    step();
    wr_en = 1'b0;
    sh_valid[idx] = 1'b1; sh_mod[idx] = 1'b1; sh_val[idx] = v;
  endtask

  task automatic fill(input int idx, input logic [DW-1:0] v);
    fill_v = 1'b1; fill_idx = AW'(idx); fill_data = v;
    step();
    fill_v = 1'b0;
  endtask

  // Miss on one port, answer after lat wait cycles, check install (R3, R4).
  task automatic miss_fetch(input int port, input int idx, input int lat);
    rd_en[port] = 1'b1; rd_addr[port] = AW'(idx);
    #1;
    chk(stall == 1'b1, "R3 stall on miss", stall, 1);
    chk(freq == 1'b0, "R3 no req in miss cycle", freq, 0);
    step();
    chk(freq == 1'b1, "R3 req pulse", freq, 1);
    chk(fidx == AW'(idx), "R3 req index", fidx, idx);
    chk(tid == cur_tid, "R3 req thread", tid, cur_tid);
    for (int k = 0; k < lat; k++) begin
      step();
      chk(stall == 1'b1 && freq == 1'b0, "R3 held while waiting", {stall, freq}, 2'b10);
    end
    fill(idx, mval(cur_tid, idx));
    chk(stall == 1'b0, "R4 stall released", stall, 0);
    chk(rd_data[port] == mval(cur_tid, idx), "R4 fill data", rd_data[port], mval(cur_tid, idx));
    sh_valid[idx] = 1'b1; sh_val[idx] = mval(cur_tid, idx);
    rd_en[port] = 1'b0;
  endtask

  task automatic check_idle_reset(input string tag);
    chk(stall == 1'b0 && freq == 1'b0 && sv_v == 1'b0, tag, {stall, freq, sv_v}, 0);
    chk(ferr == 1'b0, tag, ferr, 0);
    chk(tid == '0, tag, tid, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_en = '0; rd_addr = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    ctx_sw = 1'b0; ctx_tid = '0; fill_v = 1'b0; fill_idx = '0; fill_data = '0;
    sh_valid = '0; sh_mod = '0; cur_tid = '0;
    for (int i = 0; i < NREGS; i++) sh_val[i] = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    check_idle_reset("R1 reset state");

    // R5 write then read without fetch
    core_write(5, 32'h1234_5678);
    rd_en[0] = 1'b1; rd_addr[0] = 6'd5; #1;
    chk(stall == 1'b0, "R5 no stall after write", stall, 0);
    chk(rd_data[0] == 32'h1234_5678, "R5 written data", rd_data[0], 32'h1234_5678);
    step();
    chk(freq == 1'b0, "R5 no fetch", freq, 0);
    rd_en[0] = 1'b0;

    // R7 core write to pending register wins over fill
    rd_en[0] = 1'b1; rd_addr[0] = 6'd9;
    step();
    chk(freq == 1'b1 && fidx == 6'd9, "R7 req for 9", {freq, fidx}, {1'b1, 6'd9});
    core_write(9, 32'hC0FF_EE00);
    chk(stall == 1'b1, "R7 still waiting", stall, 1);
    fill(9, mval(0, 9));
    chk(stall == 1'b0, "R7 released", stall, 0);
    chk(rd_data[0] == 32'hC0FF_EE00, "R7 core data wins", rd_data[0], 32'hC0FF_EE00);
    rd_en[0] = 1'b0;

    // R6 two misses, port 0 first even with larger index
    rd_en = 2'b11; rd_addr[0] = 6'd20; rd_addr[1] = 6'd11; #1;
    chk(stall == 1'b1, "R6 stall", stall, 1);
    step();
    chk(freq == 1'b1 && fidx == 6'd20, "R6 port0 first", fidx, 20);
    fill(20, mval(0, 20));
    chk(stall == 1'b1 && freq == 1'b0, "R6 stall held between", {stall, freq}, 2'b10);
    step();
    chk(freq == 1'b1 && fidx == 6'd11, "R6 port1 second", fidx, 11);
    chk(stall == 1'b1, "R6 stall held", stall, 1);
    fill(11, mval(0, 11));
    chk(stall == 1'b0, "R6 released", stall, 0);
    chk(rd_data[0] == mval(0, 20), "R6 port0 data", rd_data[0], mval(0, 20));
    chk(rd_data[1] == mval(0, 11), "R6 port1 data", rd_data[1], mval(0, 11));
    rd_en = '0;
    sh_valid[20] = 1'b1; sh_val[20] = mval(0, 20);
    sh_valid[11] = 1'b1; sh_val[11] = mval(0, 11);

    // Sweep: misses fetched on port 0, all registers, varied latency (R3, R4)
    for (int i = 0; i < NREGS; i++) begin
      if (!sh_valid[i]) miss_fetch(0, i, i % 3);
    end
    // R2 hits on port 1 for every register
    for (int i = 0; i < NREGS; i++) begin
      rd_en[1] = 1'b1; rd_addr[1] = AW'(i); #1;
      chk(stall == 1'b0, "R2 hit no stall", stall, 0);
      chk(rd_data[1] == sh_val[i], "R2 hit data", rd_data[1], sh_val[i]);
      step();
    end
    rd_en = '0;

    // R8 / R11 / R12 save walk
    core_write(0, 32'h0000_0A0A);
    core_write(63, 32'h6363_6363);
    ctx_sw = 1'b1; ctx_tid = 4'd3;
    step();
    ctx_sw = 1'b0;
    begin
      bit first = 1'b1;
      for (int i = 0; i < NREGS; i++) begin
        if (sh_mod[i]) begin
          chk(sv_v == 1'b1 && stall == 1'b1, "R8 save valid", {sv_v, stall}, 2'b11);
          chk(sv_idx == AW'(i), "R8 save index ascending", sv_idx, i);
          chk(sv_data == sh_val[i], "R8 save data", sv_data, sh_val[i]);
          chk(tid == 4'd0, "R8 save tagged with old thread", tid, 0);
          if (first) begin
            wr_en = 1'b1; wr_addr = 6'd40; wr_data = 32'hDEAD_0040;
          end
          step();
          wr_en = 1'b0;
          first = 1'b0;
        end
      end
    end
    chk(sv_v == 1'b0 && stall == 1'b1, "R12 no extra saves", {sv_v, stall}, 2'b01);
    step();
    chk(stall == 1'b0 && tid == 4'd3, "R8 new thread", {stall, tid}, {1'b0, 4'd3});
    sh_valid = '0; sh_mod = '0; cur_tid = 4'd3;
    rd_en[0] = 1'b1; rd_addr[0] = 6'd5; #1;
    chk(stall == 1'b1, "R8 registers cleared", stall, 1);
    rd_en[0] = 1'b0;
    miss_fetch(0, 5, 0);
    miss_fetch(1, 40, 1);
    chk(rd_data[1] != 32'hDEAD_0040, "R11 write during save ignored", rd_data[1], mval(3, 40));

    // R9 switch during outstanding fetch
    core_write(12, 32'h1212_0012);
    rd_en[0] = 1'b1; rd_addr[0] = 6'd7;
    step();
    chk(freq == 1'b1 && fidx == 6'd7 && tid == 4'd3, "R9 req old thread", {freq, fidx, tid}, {1'b1, 6'd7, 4'd3});
    ctx_sw = 1'b1; ctx_tid = 4'd5;
    step();
    ctx_sw = 1'b0;
    chk(sv_v == 1'b0 && stall == 1'b1, "R9 no save while waiting", {sv_v, stall}, 2'b01);
    step();
    chk(sv_v == 1'b0, "R9 no save while waiting 2", sv_v, 0);
    fill(7, mval(3, 7));
    chk(sv_v == 1'b1 && sv_idx == 6'd12, "R9 save after fill", {sv_v, sv_idx}, {1'b1, 6'd12});
    chk(sv_data == 32'h1212_0012 && tid == 4'd3, "R9 save data", sv_data, 32'h1212_0012);
    step();
    chk(sv_v == 1'b0 && stall == 1'b1, "R12 reload not saved", {sv_v, stall}, 2'b01);
    step();
    chk(tid == 4'd5 && stall == 1'b1 && freq == 1'b0, "R9 thread switched, refetch pending", {tid, stall, freq}, {4'd5, 2'b10});
    cur_tid = 4'd5;
    step();
    chk(freq == 1'b1 && fidx == 6'd7 && tid == 4'd5, "R9 refetch new thread", {freq, fidx, tid}, {1'b1, 6'd7, 4'd5});
    fill(7, mval(5, 7));
    chk(stall == 1'b0 && rd_data[0] == mval(5, 7), "R9 new thread data", rd_data[0], mval(5, 7));
    rd_en[0] = 1'b0;

    // R10 mismatched fill
    rd_en[0] = 1'b1; rd_addr[0] = 6'd30;
    step();
    chk(freq == 1'b1 && fidx == 6'd30, "R10 req", fidx, 30);
    chk(ferr == 1'b0, "R10 no error yet", ferr, 0);
    fill(31, 32'hBAD0_0031);
    chk(ferr == 1'b1 && stall == 1'b1, "R10 mismatch flagged, still waiting", {ferr, stall}, 2'b11);
    fill(30, mval(5, 30));
    chk(stall == 1'b0 && rd_data[0] == mval(5, 30), "R10 bad fill ignored", rd_data[0], mval(5, 30));
    chk(ferr == 1'b1, "R10 error sticky", ferr, 1);
    rd_en[0] = 1'b0;
    step();
    fill(3, 32'h0);
    chk(ferr == 1'b1 && stall == 1'b0, "R10 unsolicited fill", {ferr, stall}, 2'b10);

    // R1 reset again clears everything
    rst_n = 1'b0;
    step();
    check_idle_reset("R1 reset in progress");
    rst_n = 1'b1;
    repeat (4) step();
    check_idle_reset("R1 after reset");
    rd_en[0] = 1'b1; rd_addr[0] = 6'd30; #1;
    chk(stall == 1'b1, "R1 registers absent after reset", stall, 1);
    step();
    chk(freq == 1'b1 && tid == 4'd0, "R1 fetch under thread 0", {freq, tid}, {1'b1, 4'd0});
    fill(30, mval(0, 30));
    chk(stall == 1'b0, "R1 fill completes", stall, 0);
    rd_en[0] = 1'b0;
    step();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule